// File: doc/BRIEF.md
# DMA Error Status Capture

This block keeps the error record for the DMA side of a host bridge. It has two banks of status: one for uncorrectable errors and one for correctable errors. Both share one register that holds the failing address. Each error event arrives as a single-cycle strobe with its attributes: the class, the kind of access, the address, a 16-bit byte mask, a block-transfer flag and, for correctable errors, an 8-bit ECC syndrome.

The first error in a bank is the primary error. It sets a primary flag and records its full context. Any error that arrives while a primary flag is still set only raises a secondary flag, and the recorded context stays as it was. Software reads the banks through a small word-indexed register port and clears flags by writing ones to them. An interrupt output is asserted while any enabled bank holds a flag.

Top module: `dma_err_capture`

## Requirements
- R1: After a synchronous reset, both status words, the failing-address register and the control register read 0, and `irq` is low.
- R2: An event whose bank has no primary flag set becomes that bank's primary error. Kind code 0 (read) sets bit 62, kind 1 (write) sets bit 61, and kind 2 (translation, uncorrectable bank only) sets bit 56. The event also captures its byte mask into bits [47:32], address bits [5:3] into bits [31:29], its block flag into bit 23 and, in the correctable bank only, its syndrome into bits [55:48]. Its full address is loaded into the shared failing-address register.
- R3: An event that arrives while its bank holds a primary flag sets only the matching secondary flag: bit 59 for read, bit 58 for write, and bit 57 for a translation event in the uncorrectable bank. The captured context and the failing address stay unchanged.
- R4: A register write of 1 to a flag bit clears that flag. A 0 leaves the flag as it is, and the context fields cannot be written.
- R5: When a clearing write and a new event fall in the same cycle, the event is judged against the flags that remain after the clear. If the clear removes the primary flag, the event becomes the new primary and captures its context.
- R6: Register index 2 reads the shared failing address, zero-extended to 64 bits. Index 3 reads the same value.
- R7: An event is ignored, with no flag and no capture, if its kind code is 3, or if it is a translation event (kind 2) sent to the correctable bank.
- R8: Control register index 4 holds bit 0 as the uncorrectable-bank interrupt enable and bit 1 as the correctable-bank enable. `irq` is registered. It equals the OR, over the two banks, of (the bank has any flag set AND that bank's enable is set), one cycle after the flags or enables change.
- R9: Event class 0 selects the uncorrectable bank (status at index 0) and class 1 selects the correctable bank (index 1). `reg_rdata` is registered and shows the word at `reg_idx` one cycle later. Unmapped indexes read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Error event strobe |
| ev_cls | input | 1 | Event class: 0 uncorrectable, 1 correctable |
| ev_kind | input | 2 | 0 read, 1 write, 2 translation, 3 none |
| ev_addr | input | ADDR_W | Address of the failing transfer |
| ev_bmask | input | 16 | Byte mask of the failing transfer |
| ev_blk | input | 1 | Transfer was a block operation |
| ev_synd | input | 8 | ECC syndrome (correctable class) |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The software clear and the capture of a new event can hit the same bank in the same cycle. The bench provokes this by driving a write-one clear and an event strobe in one clock. In one case the clear removes the standing primary flag, and the event must become a new primary with its own byte mask, offset and address. In the other case the clear hits only an unset secondary bit, and the event must fall to a secondary flag with the old context and address kept.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int WORD_W  = 64;
  localparam int BMASK_W = 16;
  localparam int SYND_W  = 8;
  localparam int OFF_W   = 3;
  localparam int NFLAG   = 6;
  localparam int NBANK   = 2;

  // bit positions of the status word (decoded by software)
  localparam int POS_P_RD  = 62;
  localparam int POS_P_WR  = 61;
  localparam int POS_S_RD  = 59;
  localparam int POS_S_WR  = 58;
  localparam int POS_S_XL  = 57;
  localparam int POS_P_XL  = 56;
  localparam int POS_SYND  = 48;
  localparam int POS_BMASK = 32;
  localparam int POS_OFF   = 29;
  localparam int POS_BLK   = 23;

  // internal flag vector order: [2:0] primary rd/wr/xl, [5:3] secondary
  typedef enum logic [1:0] {
    K_READ  = 2'd0,
    K_WRITE = 2'd1,
    K_XLAT  = 2'd2,
    K_NONE  = 2'd3
  } ev_kind_e;

  typedef enum logic [2:0] {
    IDX_UE_ST = 3'd0,
    IDX_CE_ST = 3'd1,
    IDX_ADDR  = 3'd2,
    IDX_ALIAS = 3'd3,
    IDX_CTRL  = 3'd4
  } reg_idx_e;

  function automatic logic [NFLAG-1:0] word_to_flags(input logic [WORD_W-1:0] w);
    return {w[POS_S_XL], w[POS_S_WR], w[POS_S_RD],
            w[POS_P_XL], w[POS_P_WR], w[POS_P_RD]};
  endfunction
endpackage

// File: rtl/dec_status_bank.sv
module dec_status_bank
  import dec_pkg::*;
#(
  parameter bit IS_CORR = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ev_hit,
  input  logic [1:0]         ev_kind,
  input  logic [BMASK_W-1:0] ev_bmask,
  input  logic [OFF_W-1:0]   ev_off,
  input  logic               ev_blk,
  input  logic [SYND_W-1:0]  ev_synd,
  input  logic               clr_we,
  input  logic [NFLAG-1:0]   clr_mask,
  output logic [WORD_W-1:0]  status_word,
  output logic               flags_any,
  output logic               capture
);
  localparam logic [NFLAG-1:0] LEGAL = IS_CORR ? 6'b011011 : 6'b111111;

  logic [NFLAG-1:0]   flag_q, flag_d, f_clr, set_v;
  logic [2:0]         kind_sel, kind_ok;
  logic               busy, take;
  logic [BMASK_W-1:0] bmask_q;
  logic [OFF_W-1:0]   off_q;
  logic               blk_q;
  logic [SYND_W-1:0]  synd_q;

  always_comb begin
    f_clr = clr_we ? (flag_q & ~clr_mask) : flag_q;
    busy  = |f_clr[2:0];
    unique case (ev_kind)
      K_READ:  kind_sel = 3'b001;
      K_WRITE: kind_sel = 3'b010;
      K_XLAT:  kind_sel = 3'b100;
      default: kind_sel = 3'b000;
    endcase
    kind_ok = kind_sel & LEGAL[2:0];
    take    = ev_hit && (|kind_ok);
    if (!take)     set_v = '0;
    else if (busy) set_v = {kind_ok, 3'b000};
    else           set_v = {3'b000, kind_ok};
    flag_d  = (f_clr | set_v) & LEGAL;
    capture = take && !busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= '0;
      bmask_q <= '0;
      off_q   <= '0;
      blk_q   <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (capture) begin
        bmask_q <= ev_bmask;
        off_q   <= ev_off;
        blk_q   <= ev_blk;
      end
    end
  end

  generate
    if (IS_CORR) begin : g_synd
      always_ff @(posedge clk) begin
        if (rst)          synd_q <= '0;
        else if (capture) synd_q <= ev_synd;
      end
    end else begin : g_nosynd
      logic unused_synd;
      assign unused_synd = ^ev_synd;
      assign synd_q = '0;
    end
  endgenerate

  always_comb begin
    status_word = '0;
    status_word[POS_P_RD] = flag_q[0];
    status_word[POS_P_WR] = flag_q[1];
    status_word[POS_P_XL] = flag_q[2];
    status_word[POS_S_RD] = flag_q[3];
    status_word[POS_S_WR] = flag_q[4];
    status_word[POS_S_XL] = flag_q[5];
    status_word[POS_SYND  +: SYND_W]  = synd_q;
    status_word[POS_BMASK +: BMASK_W] = bmask_q;
    status_word[POS_OFF   +: OFF_W]   = off_q;
    status_word[POS_BLK]  = blk_q;
    flags_any = |flag_q;
  end

  // R2
  prim_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flag_q[2:0]));

  // R3
  ctx_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    ((|flag_q[2:0]) && !(clr_we && |(clr_mask[2:0] & flag_q[2:0])))
    |=> $stable({bmask_q, off_q, blk_q, synd_q}));

  // R4
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ev_hit && (!clr_we || clr_mask == '0)) |=> $stable(flag_q));
endmodule

// File: rtl/dec_addr_latch.sv
module dec_addr_latch #(
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (rst)          addr_q <= '0;
    else if (capture) addr_q <= addr_in;
  end

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(addr_q));
endmodule

// File: rtl/dec_reg_port.sv
module dec_reg_port
  import dec_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic [WORD_W-1:0] ue_word,
  input  logic [WORD_W-1:0] ce_word,
  input  logic [ADDR_W-1:0] fail_addr,
  input  logic              ue_any,
  input  logic              ce_any,
  output logic [NBANK-1:0]  clr_we,
  output logic [NFLAG-1:0]  clr_mask,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq
);
  logic [NBANK-1:0]  en_q;
  logic [WORD_W-1:0] rd_d;
  logic              unused_wbits;

  assign unused_wbits = ^reg_wdata;
  assign clr_mask     = word_to_flags(reg_wdata);
  assign clr_we[0]    = reg_we && (reg_idx == IDX_W'(IDX_UE_ST));
  assign clr_we[1]    = reg_we && (reg_idx == IDX_W'(IDX_CE_ST));

  always_comb begin
    rd_d = '0;
    case (reg_idx)
      IDX_W'(IDX_UE_ST): rd_d = ue_word;
      IDX_W'(IDX_CE_ST): rd_d = ce_word;
      IDX_W'(IDX_ADDR),
      IDX_W'(IDX_ALIAS): rd_d = WORD_W'(fail_addr);
      IDX_W'(IDX_CTRL):  rd_d = WORD_W'(en_q);
      default:           rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (reg_we && reg_idx == IDX_W'(IDX_CTRL)) en_q <= reg_wdata[NBANK-1:0];
      reg_rdata <= rd_d;
      irq       <= (ue_any & en_q[0]) | (ce_any & en_q[1]);
    end
  end

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!ue_any && !ce_any) |=> !irq);

  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> !irq);
endmodule

// File: rtl/dma_err_capture.sv
module dma_err_capture
  import dec_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int IDX_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ev_valid,
  input  logic               ev_cls,
  input  logic [1:0]         ev_kind,
  input  logic [ADDR_W-1:0]  ev_addr,
  input  logic [BMASK_W-1:0] ev_bmask,
  input  logic               ev_blk,
  input  logic [SYND_W-1:0]  ev_synd,
  input  logic               reg_we,
  input  logic [IDX_W-1:0]   reg_idx,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata,
  output logic               irq
);
  logic [WORD_W-1:0] st_word [NBANK];
  logic [NBANK-1:0]  st_any, st_cap, clr_we;
  logic [NFLAG-1:0]  clr_mask;
  logic [ADDR_W-1:0] fail_addr;

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      dec_status_bank #(.IS_CORR(b == 1)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .ev_hit     (ev_valid && (ev_cls == b[0])),
        .ev_kind    (ev_kind),
        .ev_bmask   (ev_bmask),
        .ev_off     (ev_addr[5:3]),
        .ev_blk     (ev_blk),
        .ev_synd    (ev_synd),
        .clr_we     (clr_we[b]),
        .clr_mask   (clr_mask),
        .status_word(st_word[b]),
        .flags_any  (st_any[b]),
        .capture    (st_cap[b])
      );
    end
  endgenerate

  dec_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
    .clk    (clk),
    .rst    (rst),
    .capture(|st_cap),
    .addr_in(ev_addr),
    .addr_q (fail_addr)
  );

  dec_reg_port #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .reg_we   (reg_we),
    .reg_idx  (reg_idx),
    .reg_wdata(reg_wdata),
    .ue_word  (st_word[0]),
    .ce_word  (st_word[1]),
    .fail_addr(fail_addr),
    .ue_any   (st_any[0]),
    .ce_any   (st_any[1]),
    .clr_we   (clr_we),
    .clr_mask (clr_mask),
    .reg_rdata(reg_rdata),
    .irq      (irq)
  );
endmodule

// File: tb/tb_dma_err_capture.sv
module tb_dma_err_capture;
  localparam int AW = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_valid = 1'b0, ev_cls = 1'b0, ev_blk = 1'b0;
  logic [1:0]  ev_kind = 2'd0;
  logic [AW-1:0] ev_addr = '0;
  logic [15:0] ev_bmask = '0;
  logic [7:0]  ev_synd = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_idx = 3'd0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        irq;

  int total = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dma_err_capture #(.ADDR_W(AW)) dut (.*);

  typedef struct packed {
    logic        clr;
    logic        cls;
    logic [1:0]  kind;
    logic [15:0] addr;
    logic [15:0] bmask;
    logic        blk;
    logic [7:0]  synd;
    logic [63:0] exp_st;
    logic [15:0] exp_addr;
  } row_t;

  localparam row_t TBL [0:6] = '{
    '{1'b1, 1'b0, 2'd0, 16'h1238, 16'h00FF, 1'b1, 8'h00, 64'h4000_00FF_E080_0000, 16'h1238},
    '{1'b0, 1'b0, 2'd1, 16'h2008, 16'hF0F0, 1'b0, 8'h00, 64'h4400_00FF_E080_0000, 16'h1238},
    '{1'b0, 1'b0, 2'd2, 16'h3000, 16'h1111, 1'b0, 8'h00, 64'h4600_00FF_E080_0000, 16'h1238},
    '{1'b1, 1'b0, 2'd2, 16'h0010, 16'h0001, 1'b0, 8'h00, 64'h0100_0001_4000_0000, 16'h0010},
    '{1'b1, 1'b1, 2'd1, 16'h0FF8, 16'hFFFF, 1'b1, 8'hA5, 64'h20A5_FFFF_E080_0000, 16'h0FF8},
    '{1'b0, 1'b1, 2'd0, 16'h0040, 16'h0F0F, 1'b0, 8'h3C, 64'h28A5_FFFF_E080_0000, 16'h0FF8},
    '{1'b0, 1'b1, 2'd2, 16'h0088, 16'h00F0, 1'b0, 8'h77, 64'h28A5_FFFF_E080_0000, 16'h0FF8}
  };

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] idx, output logic [63:0] v);
    reg_idx = idx; cyc(); v = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] idx, input logic [63:0] d);
    reg_we = 1'b1; reg_idx = idx; reg_wdata = d; cyc(); reg_we = 1'b0;
  endtask

  task automatic set_ev(input logic cls, input logic [1:0] kind, input logic [15:0] a,
                        input logic [15:0] bm, input logic blk, input logic [7:0] sy);
    ev_valid = 1'b1; ev_cls = cls; ev_kind = kind; ev_addr = AW'(a);
    ev_bmask = bm; ev_blk = blk; ev_synd = sy;
  endtask

  task automatic ev(input logic cls, input logic [1:0] kind, input logic [15:0] a,
                    input logic [15:0] bm, input logic blk, input logic [7:0] sy);
    set_ev(cls, kind, a, bm, blk, sy); cyc(); ev_valid = 1'b0;
  endtask

  initial begin
    logic [63:0] v;
    cyc(); cyc(); rst = 1'b0; cyc();
    // R1 reset state
    rd(3'd0, v); chk("R1 ue status", v, 64'h0);
    rd(3'd1, v); chk("R1 ce status", v, 64'h0);
    rd(3'd2, v); chk("R1 address", v, 64'h0);
    rd(3'd4, v); chk("R1 control", v, 64'h0);
    chk("R1 irq", {63'h0, irq}, 64'h0);

    // R2 R3 R7 vector table
    foreach (TBL[i]) begin
      if (TBL[i].clr) wr({2'b00, TBL[i].cls}, 64'hFFFF_FFFF_FFFF_FFFF);
      ev(TBL[i].cls, TBL[i].kind, TBL[i].addr, TBL[i].bmask, TBL[i].blk, TBL[i].synd);
      rd({2'b00, TBL[i].cls}, v);
      chk($sformatf("R2/R3/R7 row %0d status", i), v, TBL[i].exp_st);
      rd(3'd2, v);
      chk($sformatf("R2/R3 row %0d address", i), v, {48'h0, TBL[i].exp_addr});
    end

    // R6 alias, R9 unmapped index
    rd(3'd3, v); chk("R6 alias address", v, 64'h0FF8);
    rd(3'd6, v); chk("R9 unmapped index", v, 64'h0);

    // R4 write-one-to-clear behaviour on the correctable bank
    wr(3'd1, 64'h0); rd(3'd1, v); chk("R4 zero write keeps flags", v, 64'h28A5_FFFF_E080_0000);
    wr(3'd1, 64'h0800_0000_0000_0000); rd(3'd1, v);
    chk("R4 clear secondary only", v, 64'h20A5_FFFF_E080_0000);
    wr(3'd1, 64'h00FF_FFFF_FFFF_FFFF); rd(3'd1, v);
    chk("R4 context not writable", v, 64'h20A5_FFFF_E080_0000);

    // R8 enable gating
    chk("R8 irq masked", {63'h0, irq}, 64'h0);
    wr(3'd4, 64'h2); cyc();
    chk("R8 irq ce enabled", {63'h0, irq}, 64'h1);
    rd(3'd4, v); chk("R8 control readback", v, 64'h2);

    // R5 clear of primary and new event in the same cycle
    set_ev(1'b0, 2'd0, 16'h0028, 16'h0F00, 1'b1, 8'h00);
    wr(3'd0, 64'h0100_0000_0000_0000); ev_valid = 1'b0;
    rd(3'd0, v); chk("R5 new primary after clear", v, 64'h4000_0F00_A080_0000);
    rd(3'd2, v); chk("R5 new address after clear", v, 64'h28);
    // R5 clear missing the primary: event falls to secondary (R3)
    set_ev(1'b0, 2'd1, 16'h0030, 16'h000F, 1'b0, 8'h00);
    wr(3'd0, 64'h0800_0000_0000_0000); ev_valid = 1'b0;
    rd(3'd0, v); chk("R5 R3 secondary when primary stays", v, 64'h4400_0F00_A080_0000);
    rd(3'd2, v); chk("R3 address kept", v, 64'h28);

    // R8 per-bank gating
    wr(3'd1, 64'hFFFF_FFFF_FFFF_FFFF); cyc(); cyc();
    chk("R8 irq drops with ce clear", {63'h0, irq}, 64'h0);
    wr(3'd4, 64'h3); cyc();
    chk("R8 irq ue enabled", {63'h0, irq}, 64'h1);
    wr(3'd0, 64'hFFFF_FFFF_FFFF_FFFF); cyc();
    chk("R8 irq drops when all clear", {63'h0, irq}, 64'h0);

    // R7 kind 3 is ignored
    ev(1'b0, 2'd3, 16'h0100, 16'hAAAA, 1'b0, 8'h00); cyc();
    rd(3'd0, v); chk("R7 kind 3 ignored", v, 64'h0000_0F00_A080_0000);
    rd(3'd2, v); chk("R7 kind 3 address kept", v, 64'h28);
    chk("R7 kind 3 no irq", {63'h0, irq}, 64'h0);

    // R1 reset mid run
    ev(1'b1, 2'd0, 16'h0008, 16'h0003, 1'b1, 8'h12);
    rst = 1'b1; cyc(); rst = 1'b0;
    rd(3'd1, v); chk("R1 reset clears ce", v, 64'h0);
    rd(3'd4, v); chk("R1 reset clears control", v, 64'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule